// File: doc/BRIEF.md
# Sector transfer termination controller

This block follows a disk data transfer that spans one sector or several consecutive sectors and decides when and how it ends. A command loads the first sector number, the last sector number allowed on the track, and a size code. After that, the block counts the bytes that the disk side moves through its own end of the data buffer. At each sector boundary it either moves on to the next sector number or closes the transfer.

A transfer can close for three reasons. The first is an explicit terminal-count pulse from the DMA side. The second is the host failing to keep up, seen as an underrun or an overrun when the disk side moves a byte. The third is reaching the last allowed sector. The first two can happen partway through a sector. In that case the block keeps counting filler or discarded bytes until the sector is whole, and only then closes.

On closing, the block gives a one-cycle done pulse, which starts the result phase, and a status flag. The flag is low when terminal count caused the end and high for any implicit end. The flag keeps its value until the next command starts. Only disk-side byte strobes count as progress. On a host-to-disk transfer, the host can therefore finish writing well before the final sector is counted complete.

Top module: `sector_end_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy, done and abnormal are 0 and cur_sec is 0.
- R2: A start pulse while idle makes busy 1 and cur_sec equal to start_sec in the following cycle. A start pulse while busy changes neither busy nor cur_sec, nor the byte count already in progress.
- R3: A sector holds 128 << size_code bytes, where size_code is sampled at the accepted start. Only byte_stb pulses while busy advance the byte count, and the count restarts at each sector boundary.
- R4: At a sector boundary where no end condition holds, cur_sec increments by one and busy stays 1.
- R5: A tc pulse while busy, on any byte of a sector including the last, ends the transfer at the boundary of that sector with abnormal = 0.
- R6: host_miss high together with byte_stb marks a host underrun or overrun. The transfer still runs to the end of the current sector, then ends with abnormal = 1.
- R7: At the boundary of the sector whose number equals eot_sec, with no tc and no miss seen, the transfer ends with abnormal = 1.
- R8: If tc was seen in the sector, the end is normal (abnormal = 0) even when a miss or the EOT sector applies at the same boundary.
- R9: done is high for exactly one cycle, the cycle after the final byte_stb is sampled. busy is 0 in that same cycle. abnormal holds its value while idle and is cleared by the next accepted start.
- R10: While idle, tc, byte_stb and host_miss have no effect. cur_sec, abnormal and busy stay put, and a later transfer is not shortened by a tc pulse given while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command start pulse; accepted only while idle |
| start_sec | input | SEC_W | First sector number of the transfer |
| eot_sec | input | SEC_W | Last sector number allowed (end of track) |
| size_code | input | SZ_W | Sector size code; sector is 128 << size_code bytes |
| byte_stb | input | 1 | Disk side moved one byte through its end of the buffer |
| host_miss | input | 1 | With byte_stb: host underrun or overrun on this byte |
| tc | input | 1 | Explicit terminal count pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse opening the result phase |
| abnormal | output | 1 | Status at the end: 0 for terminal count, 1 for an implicit end |
| cur_sec | output | SEC_W | Sector number being transferred (last one after the end) |

## Verification
All outputs are registered, so each result is due exactly one clock after the edge that samples its cause. busy and cur_sec follow one cycle after an accepted start. done, the status flag and the falling busy follow one cycle after the final byte strobe of a sector.

Inputs change on the falling edge. A behavioural model updates on the rising edge from the same inputs and is compared with the outputs 1 ns after that edge, every cycle. The end-of-transfer checks record how many strobes had been issued when done was seen, and compare that count with the sector arithmetic worked out from the size code, the start sector and the EOT sector.

// File: rtl/sector_end_pkg.sv
// Package: shared types for the sector transfer termination controller.
// Assumes: nothing beyond standard SystemVerilog.
package sector_end_pkg;

    // Reason a transfer closes at a sector boundary, in priority order.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,   // keep going
        END_TC   = 2'd1,   // explicit terminal count, normal status
        END_HOST = 2'd2,   // host underrun/overrun, abnormal status
        END_EOT  = 2'd3    // last allowed sector reached, abnormal status
    } end_cause_e;

endpackage

// File: rtl/sec_byte_counter.sv
// Module: sec_byte_counter
// Counts disk-side bytes inside the current sector and flags the last byte.
// The sector length is 2**(BASE_LOG2 + code) bytes, with the code captured
// when a transfer is loaded. The index wraps to zero on its own at each
// boundary. Assumes stb is already qualified with the transfer being busy.
module sec_byte_counter #(
    parameter int BASE_LOG2 = 7,
    parameter int SZ_W      = 3,
    localparam int CNT_W    = BASE_LOG2 + (1 << SZ_W) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SZ_W-1:0] code_in,
    input  logic            stb,
    output logic            sector_end
);

    logic [SZ_W-1:0]  code_q;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] last_idx;
    int               shamt;

    // Index of the final byte of a sector for the captured size code.
    always_comb begin
        shamt    = BASE_LOG2 + int'(code_q);
        last_idx = (CNT_W'(1) << shamt) - CNT_W'(1);
    end

    assign sector_end = stb && (idx == last_idx);

    // Byte index: cleared on load, stepped on each strobe, wrapped at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            code_q <= '0;
        end else if (load) begin
            idx    <= '0;
            code_q <= code_in;
        end else if (sector_end) begin
            idx    <= '0;
        end else if (stb) begin
            idx    <= idx + CNT_W'(1);
        end
    end

    // R3: the index returns to zero after the last byte of a sector.
    a_r3_wrap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        sector_end && !load |=> idx == '0);

    // R3: without a strobe or a load the count does not move.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb && !load |=> $stable(idx));

    // R3: the index never passes the last byte of the sector.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= last_idx);

endmodule

// File: rtl/sec_number_tracker.sv
// Module: sec_number_tracker
// Holds the current sector number and the end-of-track sector number.
// Compares the two to flag the last allowed sector.
// Assumes the start sector is not above the EOT sector. Otherwise the
// count wraps through the whole sector range before reaching EOT.
module sec_number_tracker #(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] start_sec,
    input  logic [SEC_W-1:0] eot_sec,
    input  logic             advance,
    output logic [SEC_W-1:0] cur_sec,
    output logic             at_eot
);

    logic [SEC_W-1:0] eot_q;

    assign at_eot = (cur_sec == eot_q);

    // Sector registers: loaded at the start of a command, stepped at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sec <= '0;
            eot_q   <= '0;
        end else if (load) begin
            cur_sec <= start_sec;
            eot_q   <= eot_sec;
        end else if (advance) begin
            cur_sec <= cur_sec + SEC_W'(1);
        end
    end

    // R4: a boundary that does not end the transfer steps the sector by one.
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> cur_sec == $past(cur_sec) + SEC_W'(1));

    // R2: a load takes the commanded first sector.
    a_r2_load_sec: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_sec == $past(start_sec));

endmodule

// File: rtl/sec_end_arbiter.sv
// Module: sec_end_arbiter
// Owns the busy state and decides how a transfer ends. Terminal count and
// host misses seen during a sector are held until its last byte. At that
// boundary the highest-priority cause (terminal count, then host miss,
// then EOT) closes the transfer and sets the status flag.
// Assumes miss_now is already qualified with a byte strobe while busy.
module sec_end_arbiter
    import sector_end_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic tc,
    input  logic miss_now,
    input  logic sector_end,
    input  logic at_eot,
    output logic finish,
    output logic busy,
    output logic done,
    output logic abnormal
);

    logic       tc_seen;
    logic       miss_seen;
    logic       tc_any;
    logic       miss_any;
    end_cause_e cause;

    // Rank the end conditions seen so far in this sector.
    always_comb begin
        tc_any   = tc_seen || (tc && busy);
        miss_any = miss_seen || miss_now;
        if (tc_any)        cause = END_TC;
        else if (miss_any) cause = END_HOST;
        else if (at_eot)   cause = END_EOT;
        else               cause = END_NONE;
        finish = busy && sector_end && (cause != END_NONE);
    end

    // Transfer state, pending end requests and the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            abnormal  <= 1'b0;
            tc_seen   <= 1'b0;
            miss_seen <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                busy      <= 1'b1;
                abnormal  <= 1'b0;
                tc_seen   <= 1'b0;
                miss_seen <= 1'b0;
            end else if (finish) begin
                busy      <= 1'b0;
                abnormal  <= (cause != END_TC);
            end else if (busy) begin
                if (tc)       tc_seen   <= 1'b1;
                if (miss_now) miss_seen <= 1'b1;
            end
        end
    end

    // R9: done never lasts two cycles.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the transfer is idle while done is shown.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: busy only drops together with the done pulse.
    a_r9_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: status holds while idle and no command arrives.
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !accept |=> $stable(abnormal));

    // R5: a terminal count held until the boundary gives normal status.
    a_r5_tc_normal: assert property (@(posedge clk) disable iff (!rst_n)
        finish && tc_seen |=> !abnormal);

    // R6: a held host miss without terminal count gives abnormal status.
    a_r6_miss_abnormal: assert property (@(posedge clk) disable iff (!rst_n)
        finish && miss_seen && !tc_seen && !tc |=> abnormal);

endmodule

// File: rtl/sector_end_ctrl.sv
// Module: sector_end_ctrl (top)
// Follows a single-sector or multi-sector transfer and signals its end.
// It ties together the byte counter, the sector tracker and the end
// arbiter. Assumes byte_stb marks bytes moved on the disk side of the
// buffer, so host-side writes never count as progress.
module sector_end_ctrl
    import sector_end_pkg::*;
#(
    parameter int SEC_W     = 8,
    parameter int SZ_W      = 3,
    parameter int BASE_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEC_W-1:0] start_sec,
    input  logic [SEC_W-1:0] eot_sec,
    input  logic [SZ_W-1:0]  size_code,
    input  logic             byte_stb,
    input  logic             host_miss,
    input  logic             tc,
    output logic             busy,
    output logic             done,
    output logic             abnormal,
    output logic [SEC_W-1:0] cur_sec
);

    logic accept;
    logic cnt_stb;
    logic miss_now;
    logic sector_end;
    logic at_eot;
    logic finish;
    logic advance;

    // Qualify the command and the strobes with the transfer state.
    always_comb begin
        accept   = start && !busy;
        cnt_stb  = byte_stb && busy;
        miss_now = cnt_stb && host_miss;
        advance  = sector_end && !finish;
    end

    sec_byte_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .SZ_W      (SZ_W)
    ) u_bytes (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .code_in    (size_code),
        .stb        (cnt_stb),
        .sector_end (sector_end)
    );

    sec_number_tracker #(
        .SEC_W (SEC_W)
    ) u_sectors (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .start_sec (start_sec),
        .eot_sec   (eot_sec),
        .advance   (advance),
        .cur_sec   (cur_sec),
        .at_eot    (at_eot)
    );

    sec_end_arbiter u_end (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .tc         (tc),
        .miss_now   (miss_now),
        .sector_end (sector_end),
        .at_eot     (at_eot),
        .finish     (finish),
        .busy       (busy),
        .done       (done),
        .abnormal   (abnormal)
    );

    // R10: while idle and without a command the sector number is frozen.
    a_r10_idle_sector: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(cur_sec));

    // R10: while idle, strobes and terminal count do not start a transfer.
    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy);

endmodule

// File: tb/sector_end_ctrl_tb.sv
module sector_end_ctrl_tb;

    localparam int SEC_W = 8;
    localparam int SZ_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [SEC_W-1:0] start_sec = '0;
    logic [SEC_W-1:0] eot_sec = '0;
    logic [SZ_W-1:0]  size_code = '0;
    logic             byte_stb = 1'b0;
    logic             host_miss = 1'b0;
    logic             tc = 1'b0;
    logic             busy, done, abnormal;
    logic [SEC_W-1:0] cur_sec;

    int checks = 0;
    int fails  = 0;
    int nstb   = 0;
    int dones  = 0;
    int end_stb = -1;
    logic end_abn = 1'b0;

    // Reference model state
    bit m_busy = 0, m_done = 0, m_abn = 0, m_tc = 0, m_miss = 0;
    int m_sec = 0, m_eot = 0, m_size = 128, m_idx = 0;

    always #2 clk = ~clk;

    sector_end_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_sec(start_sec),
        .eot_sec(eot_sec), .size_code(size_code), .byte_stb(byte_stb),
        .host_miss(host_miss), .tc(tc), .busy(busy), .done(done),
        .abnormal(abnormal), .cur_sec(cur_sec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each edge, then compare just after it.
    always @(posedge clk) begin
        bit tcn, missn;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_abn = 0; m_tc = 0; m_miss = 0;
            m_sec = 0; m_eot = 0; m_idx = 0; m_size = 128;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_sec = int'(start_sec); m_eot = int'(eot_sec);
                    m_size = 128 << int'(size_code); m_idx = 0;
                    m_tc = 0; m_miss = 0; m_abn = 0;
                end
            end else begin
                tcn   = m_tc | tc;
                missn = m_miss | (byte_stb & host_miss);
                m_tc = tcn; m_miss = missn;
                if (byte_stb) begin
                    if (m_idx == m_size - 1) begin
                        m_idx = 0;
                        if (tcn || missn || m_sec == m_eot) begin
                            m_done = 1; m_busy = 0; m_abn = !tcn;
                        end else begin
                            m_sec = (m_sec + 1) % 256;
                        end
                    end else begin
                        m_idx++;
                    end
                end
            end
        end
        #1;
        if (rst_n) begin
            chk(busy == m_busy, "R2 busy", busy, m_busy);
            chk(done == m_done, "R9 done", done, m_done);
            chk(abnormal == m_abn, "R6 abnormal", abnormal, m_abn);
            chk(int'(cur_sec) == m_sec, "R4 cur_sec", cur_sec, m_sec);
            if (done) begin
                dones++; end_stb = nstb; end_abn = abnormal;
            end
        end
    end

    task automatic go(input int s, input int e, input int c);
        @(negedge clk);
        start = 1; start_sec = SEC_W'(s); eot_sec = SEC_W'(e); size_code = SZ_W'(c);
        @(negedge clk);
        start = 0; nstb = 0; dones = 0; end_stb = -1;
    endtask

    task automatic feed(input int n, input int gap, input int tc_at, input int miss_at);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            byte_stb = 1; tc = (i == tc_at); host_miss = (i == miss_at); nstb++;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                byte_stb = 0; tc = 0; host_miss = 0;
            end
        end
        @(negedge clk);
        byte_stb = 0; tc = 0; host_miss = 0;
    endtask

    task automatic expect_end(input string tag, input int at, input bit abn, input int sec);
        chk(dones == 1, {tag, " done count"}, dones, 1);
        chk(end_stb == at, {tag, " strobes at done"}, end_stb, at);
        chk(end_abn == abn, {tag, " status"}, end_abn, abn);
        chk(int'(cur_sec) == sec, {tag, " final sector"}, cur_sec, sec);
        chk(busy == 0, {tag, " idle"}, busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is still applied
        chk(busy == 0 && done == 0 && abnormal == 0 && cur_sec == 0,
            "R1 reset outputs", {busy, done, abnormal}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R7 R3 R4: sectors 1..3 of 128 bytes, EOT end after 384 strobes
        go(1, 3, 0);
        feed(400, 0, -1, -1);
        expect_end("R7 eot end", 384, 1, 3);
        // R10: strobes after the end changed nothing
        chk(cur_sec == 3, "R10 idle strobes sector", cur_sec, 3);

        // R5: tc at strobe 200 (sector 6) ends at strobe 256, normal
        go(5, 9, 0);
        feed(300, 1, 200, -1);
        expect_end("R5 tc mid sector", 256, 0, 6);

        // R6 R3: size 256, miss at byte 30, sector completed anyway
        go(2, 4, 1);
        feed(600, 0, -1, 30);
        expect_end("R6 host miss", 256, 1, 2);
        repeat (5) @(negedge clk);
        chk(abnormal == 1, "R9 status held while idle", abnormal, 1);

        // R8: tc and miss in a single EOT sector, normal wins
        go(0, 0, 0);
        chk(abnormal == 0, "R9 status cleared by start", abnormal, 0);
        feed(128, 0, 50, 60);
        expect_end("R8 tc priority", 128, 0, 0);

        // R5: tc on the final byte of the sector
        go(7, 20, 0);
        feed(200, 0, 128, -1);
        expect_end("R5 tc on last byte", 128, 0, 7);

        // R2: start while busy is ignored
        go(3, 5, 0);
        feed(10, 0, -1, -1);
        @(negedge clk); start = 1; start_sec = 8'd9; eot_sec = 8'd9;
        @(negedge clk); start = 0;
        @(negedge clk);
        chk(cur_sec == 3, "R2 busy start ignored", cur_sec, 3);
        feed(374, 0, -1, -1);
        expect_end("R2 continued transfer", 384, 1, 5);

        // R10: tc while idle does not shorten the next transfer
        @(negedge clk); tc = 1; host_miss = 1; byte_stb = 1;
        @(negedge clk); tc = 0; host_miss = 0; byte_stb = 0;
        @(negedge clk);
        chk(busy == 0 && cur_sec == 5, "R10 idle pulses", cur_sec, 5);
        go(1, 2, 0);
        feed(300, 0, -1, -1);
        expect_end("R10 idle tc ignored", 256, 1, 2);

        // R6 R3: 512-byte sectors with gaps, miss in the second sector
        go(0, 1, 2);
        feed(1100, 2, -1, 600);
        expect_end("R6 miss large sector", 1024, 1, 1);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule